// File: doc/BRIEF.md
# H-Bridge Drive Command and Protection Controller

This block is the digital control core of a single full-bridge driver for a brush DC motor. An enable input and two direction inputs select one of four bridge states: forward, reverse, freewheeling through both low-side switches, or freewheeling through both high-side switches. The block drives four gate-enable outputs, one per transistor, and a health output that is high while the bridge is in good order.

Every transistor has two overcurrent comparator flags. The lower flag starts current limiting. Only that transistor is switched off for a fixed number of cycles, and it then turns back on without outside help. The upper flag trips a bridge-wide shutdown that holds until enable is dropped. After each rising edge of enable, current limiting is ignored for a programmable number of cycles so the motor can draw its inrush current. The shutdown trip stays armed during that window.

Supply-low, supply-high and over-temperature flags hold the bridge off only while they are asserted. An open-load flag affects the health output only. The enable and direction inputs are resynchronised. Any change of direction passes through a dead-time so that the two switches of a leg are never on together.

Top module: `hbridge_ctrl`

## Requirements
- R1: Gate bit order is {ls_b, hs_b, ls_a, hs_a}. With enable high, dir_a=1 and dir_b=0 drive 4'b1001 (hs_a and ls_b on). dir_a=0 and dir_b=1 drive 4'b0110 (ls_a and hs_b on).
- R2: With enable high, dir_a=dir_b=0 drives 4'b1010 (both low sides on). dir_a=dir_b=1 drives 4'b0101 (both high sides on).
- R3: en_in, dir_a_in and dir_b_in pass through two flops. A change made before a clock edge reaches the gates on the third rising edge. While the synchronised enable is low, all four gates are 0, whatever the direction inputs are.
- R4: After a change of the synchronised direction, all gates stay 0 for exactly DEAD_CYC+1 cycles. hs_a and ls_a are never both 1, and hs_b and ls_b are never both 1.
- R5: If oc_lim bit i (same bit order as the gates) is high while gate i is on and no mask is active, only gate i turns off at the next edge. It stays off for RETRY_CYC+1 cycles and then turns back on. The other gates and healthy do not change.
- R6: After enable rises, oc_lim is ignored during the first mask_len cycles in which the gates drive. Dropping enable and raising it again restarts this window.
- R7: Any oc_trip bit seen while the synchronised enable is high turns all gates off and drives healthy low at the next edge. This also applies inside the mask window. The state holds until the synchronised enable goes low, and healthy then returns high.
- R8: While uv_flag, ov_flag or hot_flag is high, all gates are 0 and healthy is low. At the edge after the flag clears, the gates and healthy are restored.
- R9: open_load drives healthy low at the next edge and leaves the gates unchanged.
- R10: During reset, all gates are 0 and healthy is 1.
- R11: The latched overcurrent state outranks the non-latching faults. When a supply or thermal flag clears, the bridge stays off while the latch is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_in | input | 1 | Bridge enable, asynchronous |
| dir_a_in | input | 1 | Direction input A, asynchronous |
| dir_b_in | input | 1 | Direction input B, asynchronous |
| mask_len | input | MASK_W | Length of the current-limit mask after enable, in cycles |
| oc_lim | input | 4 | Lower overcurrent flag per transistor |
| oc_trip | input | 4 | Upper overcurrent flag per transistor |
| uv_flag | input | 1 | Supply undervoltage |
| ov_flag | input | 1 | Supply overvoltage |
| hot_flag | input | 1 | Over-temperature |
| open_load | input | 1 | Open-load detected |
| hs_a | output | 1 | High-side gate enable, leg A |
| ls_a | output | 1 | Low-side gate enable, leg A |
| hs_b | output | 1 | High-side gate enable, leg B |
| ls_b | output | 1 | Low-side gate enable, leg B |
| healthy | output | 1 | High when no latched trip, supply, thermal or open-load fault is present |

## Verification
The properties assume that the comparator and fault flags are synchronous to clk. They also assume that mask_len is stable from the rise of enable to the end of the window. The bench drives every flag and mask_len only on falling edges, and it changes mask_len only while enable is low. Direction changes are spaced wider than the dead-time, except where the dead-time itself is being measured. Lower-trip pulses last one cycle, so that the retry count starts from a known edge.

// File: rtl/hb_pkg.sv
// Shared definitions for the H-bridge controller.
// Assumes gate vectors are ordered {ls_b, hs_b, ls_a, hs_a}.
package hb_pkg;

    typedef logic [3:0] gate_t;

    localparam int GHA = 0;
    localparam int GLA = 1;
    localparam int GHB = 2;
    localparam int GLB = 3;

    // Map the synchronised direction pair {a,b} to the gate pattern
    function automatic gate_t dir_pattern(input logic [1:0] dir);
        gate_t g;
        g = '0;
        unique case (dir)
            2'b10: begin g[GHA] = 1'b1; g[GLB] = 1'b1; end
            2'b01: begin g[GLA] = 1'b1; g[GHB] = 1'b1; end
            2'b00: begin g[GLA] = 1'b1; g[GLB] = 1'b1; end
            default: begin g[GHA] = 1'b1; g[GHB] = 1'b1; end
        endcase
        return g;
    endfunction

endpackage

// File: rtl/hb_sync.sv
// Two-flop synchroniser for a bundle of slow asynchronous control inputs.
// Assumes each bit is quasi-static, with no bus coherency required.
module hb_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hb_dead.sv
// Dead-time generator: flags a window with all switches off after a
// direction change. Assumes dir is already synchronous.
module hb_dead #(
    parameter int DEAD_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] dir,
    output logic       dead_on
);
    localparam int DW = $clog2(DEAD_CYC + 1);
    localparam logic [DW-1:0] DLOAD = DW'(DEAD_CYC);

    logic [1:0]    dir_prev;
    logic [DW-1:0] cnt;
    logic          chg;

    assign chg     = (dir != dir_prev);
    assign dead_on = chg || (cnt != '0);

    // Track last direction and run the off-window counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_prev <= '0;
            cnt      <= '0;
        end else begin
            dir_prev <= dir;
            if (chg)
                cnt <= DLOAD;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/hb_mask.sv
// Post-enable window during which the lower current trip is ignored.
// Assumes mask_len is held stable across the window.
module hb_mask #(
    parameter int MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [MASK_W-1:0] mask_len,
    output logic              mask_on
);
    logic              en_prev;
    logic [MASK_W-1:0] cnt;
    logic              rise;

    assign rise    = en && !en_prev;
    assign mask_on = rise || (cnt != '0);

    // Load the window on the enable edge, then count it down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_prev <= 1'b0;
            cnt     <= '0;
        end else begin
            en_prev <= en;
            if (rise)
                cnt <= mask_len;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/hb_retry.sv
// Per-transistor off-and-retry timer for the lower current trip.
// Assumes hit is only raised while the transistor is conducting.
module hb_retry #(
    parameter int RETRY_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hit,
    output logic block
);
    localparam int RW = $clog2(RETRY_CYC + 1);
    localparam logic [RW-1:0] RLOAD = RW'(RETRY_CYC);

    logic [RW-1:0] cnt;

    assign block = hit || (cnt != '0);

    // Hold the transistor off for the retry period after a hit
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en)
            cnt <= '0;
        else if (hit)
            cnt <= RLOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/hbridge_ctrl.sv
// H-bridge command decoder with two-tier overcurrent handling.
// Assumes: en/dir inputs asynchronous (synchronised here); comparator
// and fault flags synchronous to clk; gate order {ls_b,hs_b,ls_a,hs_a}.
module hbridge_ctrl
    import hb_pkg::*;
#(
    parameter int RETRY_CYC = 12,
    parameter int DEAD_CYC  = 2,
    parameter int MASK_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_in,
    input  logic              dir_a_in,
    input  logic              dir_b_in,
    input  logic [MASK_W-1:0] mask_len,
    input  logic [3:0]        oc_lim,
    input  logic [3:0]        oc_trip,
    input  logic              uv_flag,
    input  logic              ov_flag,
    input  logic              hot_flag,
    input  logic              open_load,
    output logic              hs_a,
    output logic              ls_a,
    output logic              hs_b,
    output logic              ls_b,
    output logic              healthy
);
    logic       en_sync;
    logic [1:0] dir_sync;
    logic       dead_on;
    logic       mask_on;
    logic       latched;
    logic       latch_nxt;
    logic       fault_any;
    logic       drive_ok;
    gate_t      gate_q;
    gate_t      gate_nxt;
    gate_t      lim_hit;
    gate_t      blocked;
    logic       health_q;

    hb_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({en_in, dir_a_in, dir_b_in}),
        .q     ({en_sync, dir_sync})
    );

    hb_dead #(.DEAD_CYC(DEAD_CYC)) u_dead (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir     (dir_sync),
        .dead_on (dead_on)
    );

    hb_mask #(.MASK_W(MASK_W)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_sync),
        .mask_len (mask_len),
        .mask_on  (mask_on)
    );

    assign lim_hit = oc_lim & gate_q & {4{!mask_on}};

    for (genvar i = 0; i < 4; i++) begin : g_retry
        hb_retry #(.RETRY_CYC(RETRY_CYC)) u_retry (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_sync),
            .hit   (lim_hit[i]),
            .block (blocked[i])
        );
    end

    // Combine enable, trips, faults and dead-time into the next gate state
    always_comb begin
        fault_any = uv_flag || ov_flag || hot_flag;
        latch_nxt = en_sync && (latched || (|oc_trip));
        drive_ok  = en_sync && !latch_nxt && !fault_any && !dead_on;
        gate_nxt  = drive_ok ? (dir_pattern(dir_sync) & ~blocked) : '0;
    end

    // Register gates, the overcurrent latch and the health flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q   <= '0;
            latched  <= 1'b0;
            health_q <= 1'b1;
        end else begin
            gate_q   <= gate_nxt;
            latched  <= latch_nxt;
            health_q <= !(latch_nxt || fault_any || open_load);
        end
    end

    assign hs_a    = gate_q[GHA];
    assign ls_a    = gate_q[GLA];
    assign hs_b    = gate_q[GHB];
    assign ls_b    = gate_q[GLB];
    assign healthy = health_q;

endmodule

// File: rtl/hbridge_ctrl_chk.sv
// Property checker for hbridge_ctrl, attached by bind.
// Assumes flags are synchronous to clk.
module hbridge_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_sync,
    input logic [1:0] dir_sync,
    input logic       latched,
    input logic       mask_on,
    input logic [3:0] oc_lim,
    input logic [3:0] oc_trip,
    input logic       uv_flag,
    input logic       ov_flag,
    input logic       hot_flag,
    input logic       open_load,
    input logic [3:0] gates,
    input logic       healthy
);
    // R4
    leg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gates[0] && gates[1]) && !(gates[2] && gates[3]));

    // R4
    dead_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_sync != $past(dir_sync)) |=> (gates == 4'b0000));

    // R3
    off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_sync |=> (gates == 4'b0000));

    // R5
    lim_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_on && |(oc_lim & gates)) |=> ((gates & $past(oc_lim & gates)) == 4'b0000));

    // R7
    hard_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_sync && |oc_trip) |=> (gates == 4'b0000 && !healthy));

    // R11
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && en_sync) |=> (gates == 4'b0000 && !healthy));

    // R8
    fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_flag || ov_flag || hot_flag) |=> (gates == 4'b0000 && !healthy));

    // R9
    open_health_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_load |=> !healthy);
endmodule

bind hbridge_ctrl hbridge_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_sync   (en_sync),
    .dir_sync  (dir_sync),
    .latched   (latched),
    .mask_on   (mask_on),
    .oc_lim    (oc_lim),
    .oc_trip   (oc_trip),
    .uv_flag   (uv_flag),
    .ov_flag   (ov_flag),
    .hot_flag  (hot_flag),
    .open_load (open_load),
    .gates     ({ls_b, hs_b, ls_a, hs_a}),
    .healthy   (healthy)
);

// File: tb/sim_hbridge_ctrl.sv
module sim_hbridge_ctrl;
    localparam int CLK_P  = 10;
    localparam int RETRY  = 12;
    localparam int DEAD   = 2;
    localparam int MW     = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_in = 1'b0, dir_a_in = 1'b0, dir_b_in = 1'b0;
    logic [MW-1:0] mask_len = '0;
    logic [3:0] oc_lim = '0, oc_trip = '0;
    logic uv_flag = 1'b0, ov_flag = 1'b0, hot_flag = 1'b0, open_load = 1'b0;
    logic hs_a, ls_a, hs_b, ls_b, healthy;
    logic [3:0] g;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    bit cmp_on = 1'b0;
    string cur_req = "R10";

    always #(CLK_P/2) clk = ~clk;
    assign g = {ls_b, hs_b, ls_a, hs_a};

    hbridge_ctrl #(.RETRY_CYC(RETRY), .DEAD_CYC(DEAD), .MASK_W(MW)) u0 (
        .clk(clk), .rst_n(rst_n), .en_in(en_in), .dir_a_in(dir_a_in),
        .dir_b_in(dir_b_in), .mask_len(mask_len), .oc_lim(oc_lim),
        .oc_trip(oc_trip), .uv_flag(uv_flag), .ov_flag(ov_flag),
        .hot_flag(hot_flag), .open_load(open_load), .hs_a(hs_a), .ls_a(ls_a),
        .hs_b(hs_b), .ls_b(ls_b), .healthy(healthy));

    // ---------------- behavioural reference model ----------------
    int in_hist_en[2], in_hist_a[2], in_hist_b[2];
    int m_last_dir, m_dead_left, m_en_was, m_mask_left, m_locked;
    int m_off_left[4];
    logic [3:0] m_gate = 4'b0000;
    logic m_ok = 1'b1;

    function automatic logic [3:0] want(input int a, input int b);
        if (a == 1 && b == 0) return 4'b1001;
        if (a == 0 && b == 1) return 4'b0110;
        if (a == 0 && b == 0) return 4'b1010;
        return 4'b0101;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                in_hist_en[k] = 0; in_hist_a[k] = 0; in_hist_b[k] = 0;
            end
            m_last_dir = 0; m_dead_left = 0; m_en_was = 0;
            m_mask_left = 0; m_locked = 0;
            for (int k = 0; k < 4; k++) m_off_left[k] = 0;
            m_gate = 4'b0000; m_ok = 1'b1;
        end else begin
            int en_now, dir_now, gap, ignore, lock_next, fault, go;
            logic [3:0] nxt, hit;
            en_now  = in_hist_en[1];
            dir_now = in_hist_a[1] * 2 + in_hist_b[1];
            gap     = (dir_now != m_last_dir) || (m_dead_left > 0);
            ignore  = (en_now && !m_en_was) || (m_mask_left > 0);
            lock_next = en_now && (m_locked || (oc_trip != 0));
            fault   = uv_flag || ov_flag || hot_flag;
            go      = en_now && !lock_next && !fault && !gap;
            nxt = go ? want(in_hist_a[1], in_hist_b[1]) : 4'b0000;
            for (int k = 0; k < 4; k++) begin
                hit[k] = oc_lim[k] && m_gate[k] && !ignore;
                if (hit[k] || m_off_left[k] > 0) nxt[k] = 1'b0;
            end
            // advance state
            for (int k = 0; k < 4; k++) begin
                if (!en_now) m_off_left[k] = 0;
                else if (hit[k]) m_off_left[k] = RETRY;
                else if (m_off_left[k] > 0) m_off_left[k]--;
            end
            if (dir_now != m_last_dir) m_dead_left = DEAD;
            else if (m_dead_left > 0) m_dead_left--;
            m_last_dir = dir_now;
            if (en_now && !m_en_was) m_mask_left = int'(mask_len);
            else if (m_mask_left > 0) m_mask_left--;
            m_en_was = en_now;
            m_locked = lock_next;
            m_ok = !(lock_next || fault || open_load);
            m_gate = nxt;
            in_hist_en[1] = in_hist_en[0]; in_hist_en[0] = int'(en_in);
            in_hist_a[1]  = in_hist_a[0];  in_hist_a[0]  = int'(dir_a_in);
            in_hist_b[1]  = in_hist_b[0];  in_hist_b[0]  = int'(dir_b_in);
        end
    end

    // Every-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            total++;
            if (g !== m_gate || healthy !== m_ok) begin
                bad++;
                $display("FAIL %s model compare: gates act=%b exp=%b healthy act=%b exp=%b",
                         cur_req, g, m_gate, healthy, m_ok);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_dir(input logic a, input logic b);
        dir_a_in = a; dir_b_in = b;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            finished = 1'b1;
            bad++; total++;
            $display("FAIL watchdog: act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int zeros;
        tick(2);
        cmp_on = 1'b1;
        tick(2);
        // R10 reset state
        chk("R10", "gates in reset", int'(g), 0);
        chk("R10", "healthy in reset", int'(healthy), 1);
        rst_n = 1'b1;

        // R3 disabled: gates stay off while direction toggles
        cur_req = "R3";
        set_dir(1, 0); tick(4); set_dir(1, 1); tick(4);
        chk("R3", "gates while disabled", int'(g), 0);

        // R3 enable latency: change before edge 1, gates after edge 3
        set_dir(1, 0); tick(DEAD + 4);
        en_in = 1'b1;
        tick(2);
        chk("R3", "gates after two edges", int'(g), 0);
        tick(1);
        chk("R3", "gates after three edges", int'(g), 4'b1001);

        // R1 / R2 direction patterns
        cur_req = "R1";
        chk("R1", "forward pattern", int'(g), 4'b1001);
        set_dir(0, 1); tick(DEAD + 6);
        chk("R1", "reverse pattern", int'(g), 4'b0110);
        cur_req = "R2";
        set_dir(0, 0); tick(DEAD + 6);
        chk("R2", "low-side freewheel", int'(g), 4'b1010);
        set_dir(1, 1); tick(DEAD + 6);
        chk("R2", "high-side freewheel", int'(g), 4'b0101);

        // R4 dead-time length
        cur_req = "R4";
        set_dir(1, 0); tick(3);
        zeros = 0;
        while (g == 4'b0000 && zeros < 50) begin zeros++; tick(1); end
        chk("R4", "dead-time off cycles", zeros, DEAD + 1);
        chk("R4", "pattern after dead-time", int'(g), 4'b1001);

        // R5 lower trip on hs_a: only that switch, RETRY+1 cycles
        cur_req = "R5";
        oc_lim = 4'b0001; tick(1); oc_lim = 4'b0000;
        chk("R5", "ls_b unaffected", int'(ls_b), 1);
        chk("R5", "healthy during limit", int'(healthy), 1);
        zeros = 0;
        while (hs_a == 1'b0 && zeros < 100) begin zeros++; tick(1); end
        chk("R5", "hs_a off cycles", zeros, RETRY + 1);

        // R6 mask window after enable
        cur_req = "R6";
        en_in = 1'b0; tick(5);
        mask_len = 8'd20;
        en_in = 1'b1;
        zeros = 0;
        while (g == 4'b0000 && zeros < 20) begin zeros++; tick(1); end
        oc_lim = 4'b0001; tick(1); oc_lim = 4'b0000;
        chk("R6", "hs_a kept during mask", int'(hs_a), 1);
        tick(25);
        oc_lim = 4'b0001; tick(1); oc_lim = 4'b0000;
        chk("R6", "hs_a off after mask", int'(hs_a), 0);
        tick(RETRY + 4);
        // R6 restart of mask by re-enable
        en_in = 1'b0; tick(5);
        en_in = 1'b1;
        zeros = 0;
        while (g == 4'b0000 && zeros < 20) begin zeros++; tick(1); end
        oc_lim = 4'b0001; tick(1); oc_lim = 4'b0000;
        chk("R6", "mask restarted", int'(hs_a), 1);

        // R7 hard trip inside the mask window, latched until enable drops
        cur_req = "R7";
        oc_trip = 4'b1000; tick(1); oc_trip = 4'b0000;
        chk("R7", "gates after hard trip", int'(g), 0);
        chk("R7", "healthy after hard trip", int'(healthy), 0);
        tick(10);
        chk("R7", "gates still latched", int'(g), 0);
        chk("R7", "healthy still low", int'(healthy), 0);

        // R11 latch outranks a clearing supply fault
        cur_req = "R11";
        uv_flag = 1'b1; tick(3); uv_flag = 1'b0; tick(3);
        chk("R11", "gates after fault clears under latch", int'(g), 0);
        chk("R11", "healthy under latch", int'(healthy), 0);

        cur_req = "R7";
        en_in = 1'b0; tick(4);
        chk("R7", "healthy after disable", int'(healthy), 1);
        mask_len = 8'd0;
        en_in = 1'b1; tick(6);
        chk("R7", "drive resumes after re-enable", int'(g), 4'b1001);

        // R8 non-latching faults
        cur_req = "R8";
        for (int f = 0; f < 3; f++) begin
            if (f == 0) uv_flag = 1'b1;
            else if (f == 1) ov_flag = 1'b1;
            else hot_flag = 1'b1;
            tick(1);
            chk("R8", "gates under fault", int'(g), 0);
            chk("R8", "healthy under fault", int'(healthy), 0);
            tick(3);
            uv_flag = 1'b0; ov_flag = 1'b0; hot_flag = 1'b0;
            tick(1);
            chk("R8", "gates after fault clears", int'(g), 4'b1001);
            chk("R8", "healthy after fault clears", int'(healthy), 1);
        end

        // R9 open load: health only
        cur_req = "R9";
        open_load = 1'b1; tick(1);
        chk("R9", "healthy with open load", int'(healthy), 0);
        chk("R9", "gates with open load", int'(g), 4'b1001);
        open_load = 1'b0; tick(2);
        chk("R9", "healthy after open load clears", int'(healthy), 1);

        tick(2);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule